// File: doc/BRIEF.md
# Three-State Base-Plus-Offset Store Sequencer

This block is the control sequencer and datapath of a small 16-bit processor that runs one instruction class: a store. The store writes a register value to memory at a register base plus an immediate offset. It fetches an instruction word from a synchronous single-port memory. In the next cycle it uses that word to address both read ports of an external eight-entry register file and adds the offset to the base value. In the cycle after that it writes the source value to memory.

Only one opcode value is a store. Any other opcode is a no-op: the block moves to the next word and fetches again, with no memory write.

The register file has combinational read ports, so both reads land in the same cycle as the address add. Memory reads return data one cycle after the read strobe.

Top module: `store_seq_top`

## Requirements
- R1: While reset is high, the block holds the fetch state with the program counter at zero. mem_re is 1, mem_addr is 0 and mem_we is 0. The first fetch after reset reads address 0.
- R2: In the fetch cycle the block asserts mem_re, drives mem_addr with the program counter and keeps mem_we low. mem_re is never high in two consecutive cycles.
- R3: The instruction word is decoded with fixed field positions. Bits [15:14] are the opcode, and 2'b01 means store. Bits [13:11] select the base register. Bits [10:8] select the source register. Bits [7:0] are the offset.
- R4: In the cycle after a fetch, the block drives rf_raddr_src and rf_raddr_base at the same time from the word returned on mem_rdata.
- R5: The effective address is the base register value plus the offset zero-extended to 16 bits, wrapping modulo 2^16.
- R6: In the write cycle, mem_we is high for exactly one cycle. mem_addr carries the effective address and mem_wdata carries the source register value read in the previous cycle.
- R7: A store takes exactly three cycles: fetch, address, write. The next fetch reads the program counter plus one.
- R8: A word whose opcode is not 2'b01 causes no memory write. The block fetches the next word two cycles after the fetch of that word.
- R9: When the source and base fields name the same register, that register's value is both the written data and the base of the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address (fetch or store) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after mem_re |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| rf_raddr_src | output | 3 | Register file read address, source port |
| rf_rdata_src | input | 16 | Register file read data, source port |
| rf_raddr_base | output | 3 | Register file read address, base port |
| rf_rdata_base | input | 16 | Register file read data, base port |

## Verification
The bench builds the block with its default widths: 16-bit words, 3-bit register selects and an 8-bit offset. With these widths, an offset of 0xFF on a base of 0x0001 tells zero extension apart from sign extension. A base of 0xFFF0 makes the sum wrap past the top of the address space. Directed programs also cover back-to-back stores, all three non-store opcodes, and a store whose source and base are the same register. Each program checks write timing, addresses and data, and the fetch sequence.

// File: rtl/store_seq_pkg.sv
package store_seq_pkg;
    localparam int DATA_W = 16;
    localparam int REG_AW = 3;
    localparam int OFF_W  = 8;
    localparam int OPC_W  = 2;
    localparam logic [OPC_W-1:0] OPC_STORE = 2'b01;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_ADDR  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    // Field positions: opcode [15:14], base [13:11], source [10:8], offset [7:0]
    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [REG_AW-1:0] base;
        logic [REG_AW-1:0] src;
        logic [OFF_W-1:0]  off;
    } insn_t;

    function automatic insn_t split_insn(input logic [DATA_W-1:0] word);
        return insn_t'(word);
    endfunction
endpackage

// File: rtl/store_seq_fsm.sv
module store_seq_fsm
    import store_seq_pkg::*;
#(
    parameter int PC_W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            is_store,
    output seq_state_t      state,
    output logic [PC_W-1:0] pc
);
    seq_state_t      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_ADDR;
            ST_ADDR: begin
                if (is_store) begin
                    state_d = ST_WRITE;
                end else begin
                    state_d = ST_FETCH;
                    pc_d    = pc_q + PC_W'(1);
                end
            end
            ST_WRITE: begin
                state_d = ST_FETCH;
                pc_d    = pc_q + PC_W'(1);
            end
            default: state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    assign state = state_q;
    assign pc    = pc_q;
endmodule

// File: rtl/store_seq_agen.sv
module store_seq_agen #(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm};
        end else begin : g_nopad
            assign imm_ext = imm[ADDR_W-1:0];
        end
    endgenerate

    assign ea = base + imm_ext;
endmodule

// File: rtl/store_seq_top.sv
module store_seq_top
    import store_seq_pkg::*;
#(
    parameter logic [OPC_W-1:0] STORE_CODE = OPC_STORE
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [REG_AW-1:0] rf_raddr_src,
    input  logic [DATA_W-1:0] rf_rdata_src,
    output logic [REG_AW-1:0] rf_raddr_base,
    input  logic [DATA_W-1:0] rf_rdata_base
);
    seq_state_t        state;
    logic [DATA_W-1:0] ip_q;
    insn_t             insn;
    logic              is_store;
    logic [DATA_W-1:0] ea;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Word returned by memory is valid in the address cycle
    assign insn     = split_insn(mem_rdata);
    assign is_store = (insn.opc == STORE_CODE);

    store_seq_fsm #(.PC_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .is_store (is_store),
        .state    (state),
        .pc       (ip_q)
    );

    store_seq_agen #(.ADDR_W(DATA_W), .IMM_W(OFF_W)) u_agen (
        .base (rf_rdata_base),
        .imm  (insn.off),
        .ea   (ea)
    );

    assign rf_raddr_src  = insn.src;
    assign rf_raddr_base = insn.base;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state == ST_ADDR && is_store) begin
            addr_q <= ea;
            data_q <= rf_rdata_src;
        end
    end

    assign mem_re    = (state == ST_FETCH);
    assign mem_we    = (state == ST_WRITE);
    assign mem_addr  = (state == ST_WRITE) ? addr_q : ip_q;
    assign mem_wdata = data_q;
endmodule

// File: rtl/store_seq_chk.sv
module store_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_re,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic [15:0] mem_rdata,
    input logic [15:0] rf_rdata_src,
    input logic [15:0] rf_rdata_base,
    input logic [15:0] ip
);
    assert_reset_fetch_R1: assert property (@(posedge clk)
        rst |=> (mem_re && !mem_we && mem_addr == 16'h0000));

    assert_fetch_no_write_R2: assert property (@(posedge clk) disable iff (rst)
        mem_re |-> !mem_we);

    assert_fetch_single_R2: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> !mem_re);

    assert_ea_sum_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == $past(rf_rdata_base) + {8'h00, $past(mem_rdata[7:0])}));

    assert_wdata_src_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata == $past(rf_rdata_src)));

    assert_write_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_write_then_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_re && mem_addr == $past(ip) + 16'd1));
endmodule

bind store_seq_top store_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .rf_rdata_src  (rf_rdata_src),
    .rf_rdata_base (rf_rdata_base),
    .ip            (ip_q)
);

// File: tb/tb_store_seq_top.sv
module tb_store_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [2:0]  rf_raddr_src, rf_raddr_base;
    logic [15:0] rf_rdata_src, rf_rdata_base;

    logic [15:0] imem [32];
    logic [15:0] rf   [8];

    int n_chk = 0;
    int n_bad = 0;

    int cyc;
    int nf, nw;
    logic [15:0] f_addr [32];
    int          f_cyc  [32];
    logic [15:0] w_addr [32];
    logic [15:0] w_data [32];
    int          w_cyc  [32];
    logic        logging = 1'b0;

    always #10 clk = ~clk;

    store_seq_top dut (
        .clk           (clk),
        .rst           (rst),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_we        (mem_we),
        .mem_re        (mem_re),
        .rf_raddr_src  (rf_raddr_src),
        .rf_rdata_src  (rf_rdata_src),
        .rf_raddr_base (rf_raddr_base),
        .rf_rdata_base (rf_rdata_base)
    );

    assign rf_rdata_src  = rf[rf_raddr_src];
    assign rf_rdata_base = rf[rf_raddr_base];

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= imem[mem_addr[4:0]];
        if (logging) cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (logging) begin
            if (mem_re && nf < 32) begin
                f_addr[nf] = mem_addr; f_cyc[nf] = cyc; nf = nf + 1;
            end
            if (mem_we && nw < 32) begin
                w_addr[nw] = mem_addr; w_data[nw] = mem_wdata; w_cyc[nw] = cyc; nw = nw + 1;
            end
        end
    end

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [2:0] base,
                                       input logic [2:0] src, input logic [7:0] off);
        return {op, base, src, off};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) imem[i] = 16'h0000;
        for (int i = 0; i < 8; i++) rf[i] = 16'h0000;
    endtask

    task automatic run(input int ncyc);
        logging = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        nf = 0; nw = 0; cyc = 0;
        rst = 1'b0;
        logging = 1'b1;
        #1;
        if (mem_re) begin f_addr[0] = mem_addr; f_cyc[0] = 0; nf = 1; end
        repeat (ncyc) @(negedge clk);
        logging = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mem_we in reset", {31'd0, mem_we}, 32'd0);
        chk("R1 mem_re in reset", {31'd0, mem_re}, 32'd1);
        chk("R1 mem_addr in reset", {16'd0, mem_addr}, 32'd0);
    endtask

    task automatic t_basic();
        clear_mem();
        rf[2] = 16'h1234; rf[3] = 16'h0100;
        imem[0] = mk(2'b01, 3'd3, 3'd2, 8'h05);
        run(5);
        chk("R3 R4 one write", nw, 1);
        chk("R5 address", {16'd0, w_addr[0]}, 32'h0105);
        chk("R6 data", {16'd0, w_data[0]}, 32'h1234);
        chk("R7 write cycle", w_cyc[0], 2);
        chk("R1 first fetch addr", {16'd0, f_addr[0]}, 32'd0);
        chk("R7 next fetch addr", {16'd0, f_addr[1]}, 32'd1);
        chk("R7 next fetch cycle", f_cyc[1], 3);
    endtask

    task automatic t_zext();
        clear_mem();
        rf[1] = 16'h0001; rf[6] = 16'hBEEF;
        imem[0] = mk(2'b01, 3'd1, 3'd6, 8'hFF);
        run(4);
        chk("R5 zero-extended offset", {16'd0, w_addr[0]}, 32'h0100);
        chk("R6 data zext case", {16'd0, w_data[0]}, 32'hBEEF);
    endtask

    task automatic t_wrap();
        clear_mem();
        rf[7] = 16'hFFF0; rf[0] = 16'hA5A5;
        imem[0] = mk(2'b01, 3'd7, 3'd0, 8'h20);
        run(4);
        chk("R5 wrap address", {16'd0, w_addr[0]}, 32'h0010);
        chk("R6 data wrap case", {16'd0, w_data[0]}, 32'hA5A5);
    endtask

    task automatic t_same();
        clear_mem();
        rf[5] = 16'h0200;
        imem[0] = mk(2'b01, 3'd5, 3'd5, 8'h03);
        run(4);
        chk("R9 same-reg address", {16'd0, w_addr[0]}, 32'h0203);
        chk("R9 same-reg data", {16'd0, w_data[0]}, 32'h0200);
    endtask

    task automatic t_nonstore();
        clear_mem();
        rf[1] = 16'h0040; rf[2] = 16'h7777;
        imem[0] = mk(2'b00, 3'd1, 3'd2, 8'h01);
        imem[1] = mk(2'b10, 3'd1, 3'd2, 8'h02);
        imem[2] = mk(2'b11, 3'd1, 3'd2, 8'h03);
        imem[3] = mk(2'b01, 3'd1, 3'd2, 8'h04);
        run(10);
        chk("R8 only one write", nw, 1);
        chk("R8 write cycle after no-ops", w_cyc[0], 8);
        chk("R8 write address", {16'd0, w_addr[0]}, 32'h0044);
        for (int i = 0; i < 4; i++) begin
            chk("R8 fetch addr", {16'd0, f_addr[i]}, i);
            chk("R8 fetch cycle", f_cyc[i], 2 * i);
        end
    endtask

    task automatic t_b2b();
        clear_mem();
        rf[0] = 16'h1000; rf[1] = 16'h0011; rf[2] = 16'h0022; rf[3] = 16'h0033;
        imem[0] = mk(2'b01, 3'd0, 3'd1, 8'h00);
        imem[1] = mk(2'b01, 3'd0, 3'd2, 8'h10);
        imem[2] = mk(2'b01, 3'd0, 3'd3, 8'h80);
        run(11);
        chk("R7 three writes", nw, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R7 write cycle", w_cyc[i], 3 * i + 2);
            chk("R6 write data", {16'd0, w_data[i]}, 32'h11 * (i + 1));
        end
        chk("R5 addr 0", {16'd0, w_addr[0]}, 32'h1000);
        chk("R5 addr 1", {16'd0, w_addr[1]}, 32'h1010);
        chk("R5 addr 2", {16'd0, w_addr[2]}, 32'h1080);
        for (int i = 0; i < 4; i++) begin
            chk("R2 fetch addr", {16'd0, f_addr[i]}, i);
            chk("R2 fetch cycle", f_cyc[i], 3 * i);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_basic();
        t_zext();
        t_wrap();
        t_same();
        t_nonstore();
        t_b2b();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule